// File: doc/BRIEF.md
# Timestamped Run-Length Sample Clusterizer

This block compresses a stream of 16-bit pin samples into memory words. A sample is presented with a one-cycle `tick`. A tick timestamp counts every tick from zero after reset. A sample is stored only when it differs from the sample seen on the previous tick. Stored samples are grouped into clusters of eight words, each at an 8-word-aligned address. The cluster's first slot holds the timestamp of its first sample. The remaining seven slots hold samples from consecutive ticks.

A sample that cannot extend the open cluster opens a new one at the next aligned address. This happens after a gap in ticks, after a full cluster, and on the tick where the timestamp reads zero. A cluster is forced on that zero tick even when the input is unchanged, so a reader can always resolve timestamp rollover.

The write address is split into a row field and a 9-bit in-row word field. The address wraps at the end of memory and sets a sticky flag. An enable input gates storage. Dropping it closes the open cluster, so that writing resumes at a fresh cluster boundary.

Top module: `rle_clusterizer`

## Requirements
- R1: After reset, `wr_en` is 0, `next_pos` is 0, `wrapped` is 0 and the timestamp counter is 0.
- R2: A cluster occupies eight word addresses starting at a multiple of 8. Slot 0 is the timestamp word. Slots 1 to 7 are event samples.
- R3: The timestamp word is the tick count (starting at 0 after reset, counting every tick, modulo 2^TS_W) of the cluster's first sample, zero-extended to 16 bits.
- R4: A changed sample is written into the next slot of the open cluster only if it arrives on the tick directly after that cluster's previous event and the cluster holds fewer than 7 events. Otherwise it opens a new cluster.
- R5: A tick whose sample equals the previous tick's sample writes nothing, unless R6 applies.
- R6: On every enabled tick whose timestamp is 0, a new cluster is opened with that sample, even if the sample is unchanged.
- R7: Addresses are {row, col}: `wr_col` is the low 9 bits (512 words per row) and `wr_row` is the upper ROW_W bits. `next_pos` is the address the next event word would use.
- R8: When an address step or cluster alignment passes the last word, the address wraps to 0 and `wrapped` is set and stays set until reset.
- R9: While `enable` is 0, ticks write nothing, but the timestamp and the previous-sample reference keep tracking. Dropping `enable` closes the open cluster and moves `next_pos` up to the next multiple of 8.
- R10: `tick` is never high on two adjacent cycles. An event word appears one cycle after its tick edge. A newly opened cluster writes its timestamp word one cycle after the tick edge and its first sample on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Storage gate |
| tick | input | 1 | Sample strobe |
| sample | input | WORD_W | Pin sample word |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | WORD_W | Word to write (timestamp or sample) |
| wr_row | output | ROW_W | Row field of write address |
| wr_col | output | 9 | Word offset within the row |
| next_pos | output | ROW_W+9 | Current event position {row, col} |
| wrapped | output | 1 | Sticky memory wrap flag |

## Verification
The checker assumes that the sample strobe never fires on back-to-back cycles. Under that assumption, the second word of a cluster opening never collides with a new tick. The checker also asserts this spacing as a property.

Each bench task raises `tick` for one cycle and then leaves it low for at least one cycle. `enable` is changed only between ticks. The bench uses a narrow timestamp and a small row count so that timestamp rollover and memory wrap occur within a short run. The bench's behavioural model predicts every word and address from the requirements alone.

// File: rtl/clz_pkg.sv
// Shared constants and command types for the run-length clusterizer.
// Assumes a cluster of 8 words and 512 words per memory row.
package clz_pkg;
    localparam int COL_W     = 9;
    localparam int CL_EVENTS = 7;

    typedef enum logic [1:0] {
        ADDR_HOLD,
        ADDR_STEP,
        ADDR_OPEN,
        ADDR_CLOSE
    } addr_cmd_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_PEND,
        ACT_EVENT,
        ACT_OPEN,
        ACT_CLOSE
    } act_e;
endpackage

// File: rtl/clz_front.sv
// Tick timestamp counter and change detector.
// Holds the timestamp of the current tick and the sample of the previous
// tick. Both advance on every tick, whether storage is enabled or not.
module clz_front #(
    parameter int WORD_W = 16,
    parameter int TS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] sample,
    output logic [TS_W-1:0]   ts,
    output logic              chg,
    output logic              force_cl
);
    logic [TS_W-1:0]   ts_q;
    logic [WORD_W-1:0] prev_q;

    // Advance the timestamp and remember the sample on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            prev_q <= '0;
        end else if (tick) begin
            ts_q   <= ts_q + 1'b1;
            prev_q <= sample;
        end
    end

    // Flag a level change and the rollover tick.
    always_comb begin
        ts       = ts_q;
        chg      = (sample != prev_q);
        force_cl = (ts_q == '0);
    end
endmodule

// File: rtl/clz_addr.sv
// Write-address generator with cluster alignment and a sticky wrap flag.
// Assumes one command per cycle; address arithmetic is modulo 2^AW.
module clz_addr
    import clz_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_cmd_e     cmd,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] aligned,
    output logic          wrapped
);
    logic [AW-1:0] addr_q;
    logic          wrap_q;
    logic [AW:0]   up_w;
    logic [AW:0]   nxt_w;

    // Round the address up to a cluster boundary and pick the next value.
    always_comb begin
        up_w = ({1'b0, addr_q} + (AW+1)'(7)) & ~((AW+1)'(7));
        unique case (cmd)
            ADDR_STEP:  nxt_w = {1'b0, addr_q} + (AW+1)'(1);
            ADDR_OPEN:  nxt_w = up_w + (AW+1)'(1);
            ADDR_CLOSE: nxt_w = up_w;
            default:    nxt_w = {1'b0, addr_q};
        endcase
        addr    = addr_q;
        aligned = up_w[AW-1:0];
        wrapped = wrap_q;
    end

    // Register the address and latch any carry out of the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            addr_q <= nxt_w[AW-1:0];
            if (nxt_w[AW]) wrap_q <= 1'b1;
        end
    end
endmodule

// File: rtl/clz_ctrl.sv
// Cluster controller: decides whether a tick extends the open cluster,
// opens a new one (timestamp word now, sample word next cycle) or closes
// it. Assumes ticks are at least two cycles apart.
module clz_ctrl
    import clz_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TS_W   = 16,
    parameter int AW     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic [WORD_W-1:0] sample,
    input  logic [TS_W-1:0]   ts,
    input  logic              chg,
    input  logic              force_cl,
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     aligned,
    output addr_cmd_e         cmd,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [AW-1:0]     wr_addr
);
    logic              open_q;
    logic [2:0]        cnt_q;
    logic [TS_W-1:0]   last_q;
    logic              pend_q;
    logic [WORD_W-1:0] pend_d;
    logic [WORD_W-1:0] ts_word;
    logic              cont;
    act_e              act;

    // Choose this cycle's action and the matching address command.
    always_comb begin
        ts_word           = '0;
        ts_word[TS_W-1:0] = ts;
        cont = open_q && (cnt_q != 3'(CL_EVENTS)) && !force_cl &&
               (ts == TS_W'(last_q + 1'b1));
        act = ACT_NONE;
        if (pend_q)
            act = ACT_PEND;
        else if (tick && enable && (chg || force_cl))
            act = cont ? ACT_EVENT : ACT_OPEN;
        else if (!enable && open_q)
            act = ACT_CLOSE;
        unique case (act)
            ACT_PEND, ACT_EVENT: cmd = ADDR_STEP;
            ACT_OPEN:            cmd = ADDR_OPEN;
            ACT_CLOSE:           cmd = ADDR_CLOSE;
            default:             cmd = ADDR_HOLD;
        endcase
    end

    // Carry out the action: emit a word, update cluster state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            cnt_q   <= '0;
            last_q  <= '0;
            pend_q  <= 1'b0;
            pend_d  <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            wr_addr <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (act)
                ACT_PEND: begin
                    wr_en   <= 1'b1;
                    wr_data <= pend_d;
                    wr_addr <= addr;
                    pend_q  <= 1'b0;
                end
                ACT_EVENT: begin
                    wr_en   <= 1'b1;
                    wr_data <= sample;
                    wr_addr <= addr;
                    cnt_q   <= cnt_q + 1'b1;
                    last_q  <= ts;
                end
                ACT_OPEN: begin
                    wr_en   <= 1'b1;
                    wr_data <= ts_word;
                    wr_addr <= aligned;
                    pend_q  <= 1'b1;
                    pend_d  <= sample;
                    cnt_q   <= 3'd1;
                    open_q  <= 1'b1;
                    last_q  <= ts;
                end
                ACT_CLOSE: open_q <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rle_clusterizer.sv
// Top of the run-length clusterizer. Connects the change detector, the
// cluster controller and the address generator, and splits the write
// address into row and in-row word fields. Assumes TS_W <= WORD_W.
module rle_clusterizer
    import clz_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TS_W   = 16,
    parameter int ROW_W  = 15,
    localparam int AW    = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [WORD_W-1:0] sample,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [AW-1:0]     next_pos,
    output logic              wrapped
);
    logic [TS_W-1:0] ts;
    logic            chg;
    logic            force_cl;
    logic [AW-1:0]   addr;
    logic [AW-1:0]   aligned;
    logic [AW-1:0]   wr_addr;
    addr_cmd_e       cmd;

    clz_front #(.WORD_W(WORD_W), .TS_W(TS_W)) front_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample),
        .ts(ts), .chg(chg), .force_cl(force_cl)
    );

    clz_ctrl #(.WORD_W(WORD_W), .TS_W(TS_W), .AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
        .sample(sample), .ts(ts), .chg(chg), .force_cl(force_cl),
        .addr(addr), .aligned(aligned), .cmd(cmd),
        .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr)
    );

    clz_addr #(.AW(AW)) addr_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .addr(addr), .aligned(aligned), .wrapped(wrapped)
    );

    // Split the write address and expose the current position.
    always_comb begin
        wr_row   = wr_addr[AW-1:COL_W];
        wr_col   = wr_addr[COL_W-1:0];
        next_pos = addr;
    end
endmodule

// File: rtl/rle_clusterizer_chk.sv
// Property checker for rle_clusterizer, attached with bind.
// Assumes ticks are spaced at least two cycles apart (also checked here).
module rle_clusterizer_chk #(
    parameter int ROW_W = 15,
    parameter int AW    = ROW_W + 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tick,
    input logic             wr_en,
    input logic [ROW_W-1:0] wr_row,
    input logic [8:0]       wr_col,
    input logic [AW-1:0]    next_pos,
    input logic             wrapped
);
    assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_ts_then_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_col[2:0] == 3'd0) |=> (wr_en && wr_col[2:0] == 3'd1));

    assert_pos_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (next_pos == AW'({wr_row, wr_col} + 1'b1)));

    assert_wrap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !enable) |=> !wr_en);
endmodule

bind rle_clusterizer rle_clusterizer_chk #(.ROW_W(ROW_W), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .wr_en(wr_en),
    .wr_row(wr_row), .wr_col(wr_col), .next_pos(next_pos), .wrapped(wrapped)
);

// File: tb/rle_clusterizer_tb_top.sv
module rle_clusterizer_tb_top;
    localparam int TS_W   = 8;
    localparam int ROW_W  = 2;
    localparam int AW     = ROW_W + 9;
    localparam int TS_MOD = 1 << TS_W;
    localparam int A_MOD  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic tick = 1'b0;
    logic [15:0] sample = '0;
    logic wr_en;
    logic [15:0] wr_data;
    logic [ROW_W-1:0] wr_row;
    logic [8:0] wr_col;
    logic [AW-1:0] next_pos;
    logic wrapped;

    int total = 0;
    int bad = 0;

    logic [AW+15:0] got_q[$];
    logic [AW+15:0] exp_q[$];

    int m_ts, m_cnt, m_last, m_addr;
    logic [15:0] m_prev;
    bit m_open, m_wrap, m_en;

    rle_clusterizer #(.WORD_W(16), .TS_W(TS_W), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .sample(sample),
        .wr_en(wr_en), .wr_data(wr_data), .wr_row(wr_row), .wr_col(wr_col),
        .next_pos(next_pos), .wrapped(wrapped)
    );

    always #2 clk = ~clk;

    // Collect every write away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_en) got_q.push_back({wr_row, wr_col, wr_data});
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int align_up(input int a);
        int r = ((a + 7) / 8) * 8;
        if (r >= A_MOD) begin
            m_wrap = 1'b1;
            r = r - A_MOD;
        end
        return r;
    endfunction

    task automatic push_exp(input int a, input logic [15:0] d);
        exp_q.push_back({AW'(a), d});
    endtask

    // Behavioural model of one tick, from the requirements.
    task automatic model_tick(input logic [15:0] s);
        bit chg = (s != m_prev);
        bit frc = (m_ts == 0);
        if (m_en && (chg || frc)) begin
            if (m_open && m_cnt < 7 && !frc && m_ts == (m_last + 1) % TS_MOD) begin
                push_exp(m_addr, s);
                m_addr = m_addr + 1;
                if (m_addr == A_MOD) begin m_addr = 0; m_wrap = 1'b1; end
                m_cnt++;
            end else begin
                int base = align_up(m_addr);
                push_exp(base, 16'(m_ts));
                push_exp(base + 1, s);
                m_addr = base + 2;
                m_cnt = 1;
                m_open = 1'b1;
            end
            m_last = m_ts;
        end
        m_prev = s;
        m_ts = (m_ts + 1) % TS_MOD;
    endtask

    task automatic do_tick(input logic [15:0] s);
        @(negedge clk);
        tick = 1'b1;
        sample = s;
        model_tick(s);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        enable = v;
        m_en = v;
        if (!v && m_open) begin
            m_open = 1'b0;
            m_addr = align_up(m_addr);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; enable = 1'b1; sample = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ts = 0; m_cnt = 0; m_last = 0; m_addr = 0; m_prev = '0;
        m_open = 1'b0; m_wrap = 1'b0; m_en = 1'b1;
        got_q.delete();
        exp_q.delete();
    endtask

    // Drain pending writes and compare against the model.
    task automatic compare(input string tag);
        repeat (3) @(negedge clk);
        check(got_q.size() == exp_q.size(), {tag, " word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            check(got_q[i] == exp_q[i], $sformatf("%s word %0d {addr,data}", tag, i),
                  int'(got_q[i]), int'(exp_q[i]));
        check(next_pos == AW'(m_addr), {tag, " next_pos R7"}, int'(next_pos), m_addr);
        check(wrapped == m_wrap, {tag, " wrapped R8"}, int'(wrapped), int'(m_wrap));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        do_reset();
        check(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
        check(next_pos == '0, "R1 next_pos", int'(next_pos), 0);
        check(wrapped == 1'b0, "R1 wrapped", int'(wrapped), 0);
        repeat (4) @(negedge clk);
        check(got_q.size() == 0, "R1 no writes idle", got_q.size(), 0);
    endtask

    task automatic t_burst();
        do_reset();
        for (int i = 1; i <= 9; i++) do_tick(16'(i));
        compare("R2 R3 R4 burst");
    endtask

    task automatic t_quiet();
        do_reset();
        do_tick(16'h0005);
        for (int i = 0; i < 5; i++) do_tick(16'h0005);
        compare("R5 unchanged");
        do_tick(16'h0006);
        compare("R4 R3 gap reopen");
    endtask

    task automatic t_force();
        do_reset();
        for (int i = 0; i < 300; i++) do_tick(16'h00AA);
        compare("R6 forced rollover");
    endtask

    task automatic t_enable();
        do_reset();
        do_tick(16'h000A);
        do_tick(16'h000B);
        set_enable(1'b0);
        check(next_pos == AW'(8), "R9 closed to boundary", int'(next_pos), 8);
        do_tick(16'h000C);
        do_tick(16'h000D);
        compare("R9 disabled ticks");
        set_enable(1'b1);
        do_tick(16'h000D);
        do_tick(16'h000E);
        compare("R9 resume");
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 6000 && !m_wrap; i++) do_tick(16'(1 + (i % 2)));
        for (int i = 0; i < 3; i++) do_tick(16'(16'h0100 + i));
        compare("R8 R7 address wrap");
        repeat (5) @(negedge clk);
        check(wrapped == 1'b1, "R8 wrapped sticky", int'(wrapped), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_burst();
        t_quiet();
        t_force();
        t_enable();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule